// File: doc/BRIEF.md
# Word-Counting Program Counter with Branch Target Adder

This block sits at the front of a single-cycle processor. It holds the program counter as a count of 32-bit instruction words rather than bytes. It presents the byte address of the current instruction to instruction memory. On every enabled clock edge it moves to the next instruction, which is either the next word or a branch target.

The two least significant bits of a word-aligned byte address are always zero, so they are not stored. The counter is 30 bits wide, and the byte address is formed by appending two zero bits to it. A taken branch adds the sign-extended 16-bit word offset to the incremented count, so the adder needs no shift. The rest of the datapath supplies a branch-taken flag, the immediate and an advance enable. The block drives the instruction address and the current word count.

Top module: `word_pc_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the stored word count is loaded with the parameter `START` (default 0). The reset is synchronous and active low, and it takes priority over every other input.
- R2: `fetch_addr` always equals the stored word count in bits 31:2, with bits 1:0 equal to zero.
- R3: At a rising edge with `adv_en` high and `br_taken` low, the word count becomes its previous value plus one, and `br_offset` has no effect.
- R4: At a rising edge with `adv_en` high and `br_taken` high, the word count becomes its previous value plus one plus `br_offset` sign-extended to 30 bits.
- R5: A `br_offset` with bit 15 set is a negative word offset, which gives a backward branch. For example, 16'hFFFE moves the count to its previous value minus one.
- R6: All next-count arithmetic wraps modulo 2^30, both above the top of the range and below zero.
- R7: At a rising edge with `adv_en` low, the word count keeps its value whatever `br_taken` and `br_offset` are.
- R8: `pc_word` presents the stored word count. It changes only at rising clock edges, one edge after the inputs that cause the change.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_en | input | 1 | Advance enable; low holds the count |
| br_taken | input | 1 | Selects the branch target over the next word |
| br_offset | input | 16 | Signed branch offset in words |
| fetch_addr | output | 32 | Byte address of the current instruction |
| pc_word | output | 30 | Current word count |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it, because the only state is the word-count register and both outputs are read straight from it. The driver applies inputs at a falling edge and waits for the next rising edge. Only then does it push the expected count into the scoreboard queue. The monitor pops each entry at the following falling edge, half a cycle after the register has settled, and compares both `pc_word` and `fetch_addr`, so each expectation is matched against the cycle that produced it.

// File: rtl/wpc_pkg.sv
// Package: shared constants for the word-counting program counter.
// Assumes instructions are 32 bits wide and aligned, so a byte address
// carries a fixed number of zero bits below the word index.
package wpc_pkg;
    // Number of always-zero byte-offset bits below the word index.
    localparam int unsigned WPC_ALIGN_BITS = 2;
endpackage

// File: rtl/wpc_offset_ext.sv
// Module: wpc_offset_ext
// Sign-extends the signed word offset to the counter width and gates it
// to zero when the branch is not taken. Assumes PC_W >= IMM_W.
module wpc_offset_ext #(
    parameter int unsigned PC_W  = 30,
    parameter int unsigned IMM_W = 16
) (
    input  logic             take,
    input  logic [IMM_W-1:0] imm,
    output logic [PC_W-1:0]  ofs
);
    localparam int unsigned PAD_W = PC_W - IMM_W;

    logic [PC_W-1:0] ext;

    generate
        if (PAD_W > 0) begin : g_pad
            // Replicate the sign bit into the upper bits.
            always_comb ext = {{PAD_W{imm[IMM_W-1]}}, imm};
        end else begin : g_nopad
            // Widths match; pass the immediate through.
            always_comb ext = imm[PC_W-1:0];
        end
    endgenerate

    // Zero the offset when falling through to the next word.
    always_comb ofs = take ? ext : '0;
endmodule

// File: rtl/wpc_next_calc.sv
// Module: wpc_next_calc
// Forms the candidate next word count: current + 1 + offset, modulo 2^PC_W.
// Assumes the offset is already gated to zero for sequential flow.
module wpc_next_calc #(
    parameter int unsigned PC_W = 30
) (
    input  logic [PC_W-1:0] cur,
    input  logic [PC_W-1:0] ofs,
    output logic [PC_W-1:0] nxt
);
    // One adder chain; carry out of the top bit is discarded (wrap).
    always_comb nxt = cur + PC_W'(1) + ofs;
endmodule

// File: rtl/wpc_state_reg.sv
// Module: wpc_state_reg
// The word-count register with synchronous active-low reset and load enable.
// Assumes the reset value fits in PC_W bits.
module wpc_state_reg #(
    parameter int unsigned     PC_W  = 30,
    parameter logic [PC_W-1:0] START = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PC_W-1:0] d,
    output logic [PC_W-1:0] q
);
    // Reset wins; otherwise load when enabled, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= START;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/word_pc_seq.sv
// Module: word_pc_seq (top)
// Word-addressed program counter with next-address logic. It stores only the
// word index and appends the zero alignment bits to form the byte address.
// Assumes one instruction per enabled clock edge and aligned 32-bit words.
module word_pc_seq #(
    parameter int unsigned     PC_W  = 30,
    parameter int unsigned     IMM_W = 16,
    parameter logic [PC_W-1:0] START = '0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 adv_en,
    input  logic                                 br_taken,
    input  logic [IMM_W-1:0]                     br_offset,
    output logic [PC_W+wpc_pkg::WPC_ALIGN_BITS-1:0] fetch_addr,
    output logic [PC_W-1:0]                      pc_word
);
    import wpc_pkg::*;

    localparam int unsigned ADDR_W = PC_W + WPC_ALIGN_BITS;

    logic [PC_W-1:0] cur_w;
    logic [PC_W-1:0] ofs_w;
    logic [PC_W-1:0] nxt_w;

    wpc_offset_ext #(.PC_W(PC_W), .IMM_W(IMM_W)) u_ext (
        .take (br_taken),
        .imm  (br_offset),
        .ofs  (ofs_w)
    );

    wpc_next_calc #(.PC_W(PC_W)) u_calc (
        .cur (cur_w),
        .ofs (ofs_w),
        .nxt (nxt_w)
    );

    wpc_state_reg #(.PC_W(PC_W), .START(START)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (adv_en),
        .d     (nxt_w),
        .q     (cur_w)
    );

    // Byte address: word index above the zero alignment bits.
    always_comb fetch_addr = {cur_w, {WPC_ALIGN_BITS{1'b0}}};

    // Word count straight from the register.
    always_comb pc_word = cur_w;

    // Width sanity for the derived address bus.
    initial if (ADDR_W != $bits(fetch_addr)) $display("word_pc_seq: width mismatch");
endmodule

// File: rtl/wpc_chk.sv
// Module: wpc_chk
// Assertion checker for word_pc_seq, attached via bind below.
// Assumes the same parameters as the bound instance.
module wpc_chk #(
    parameter int unsigned     PC_W  = 30,
    parameter int unsigned     IMM_W = 16,
    parameter logic [PC_W-1:0] START = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               adv_en,
    input logic               br_taken,
    input logic [IMM_W-1:0]   br_offset,
    input logic [PC_W+1:0]    fetch_addr,
    input logic [PC_W-1:0]    pc_word
);
    logic [PC_W-1:0] sx_ofs;
    // Independent sign extension of the offset for the branch check.
    always_comb sx_ofs = PC_W'($signed(br_offset));

    // R1
    reset_load_chk: assert property (@(posedge clk)
        !rst_n |=> pc_word == START);

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr == {pc_word, 2'b00});

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en && !br_taken |=> pc_word == $past(pc_word) + PC_W'(1));

    // R4
    branch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en && br_taken |=> pc_word == $past(pc_word) + PC_W'(1) + $past(sx_ofs));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> $stable(pc_word));
endmodule

bind word_pc_seq wpc_chk #(.PC_W(PC_W), .IMM_W(IMM_W), .START(START)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_en     (adv_en),
    .br_taken   (br_taken),
    .br_offset  (br_offset),
    .fetch_addr (fetch_addr),
    .pc_word    (pc_word)
);

// File: tb/sim_word_pc_seq.sv
`timescale 1ns/1ps
module sim_word_pc_seq;
    localparam logic [29:0] ST = 30'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_en = 1'b0;
    logic        br_taken = 1'b0;
    logic [15:0] br_offset = '0;
    logic [31:0] fetch_addr;
    logic [29:0] pc_word;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [29:0] model = '0;
    logic [29:0] q_exp[$];
    string       q_tag[$];

    word_pc_seq #(.START(ST)) u0 (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .br_taken(br_taken),
        .br_offset(br_offset), .fetch_addr(fetch_addr), .pc_word(pc_word)
    );

    always #4 clk = ~clk;

    // Monitor: pop one expectation per falling edge and compare.
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [29:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_chk++;
            if (pc_word !== e) begin
                n_err++;
                $display("FAIL %s pc_word act=%h exp=%h", t, pc_word, e);
            end
            n_chk++;
            if (fetch_addr !== {e, 2'b00}) begin
                n_err++;
                $display("FAIL R2 (%s) fetch_addr act=%h exp=%h", t, fetch_addr, {e, 2'b00});
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        adv_en = 1'b1; br_taken = 1'b1; br_offset = 16'h0040;
        @(posedge clk);
        model = ST;
        q_exp.push_back(model); q_tag.push_back("R1");
        @(negedge clk);
        rst_n = 1'b1;
        adv_en = 1'b0;
    endtask

    task automatic step(input logic en, input logic tk, input logic [15:0] off, input string tag);
        @(negedge clk);
        adv_en = en; br_taken = tk; br_offset = off;
        @(posedge clk);
        if (en) model = model + 30'd1 + (tk ? {{14{off[15]}}, off} : 30'd0);
        q_exp.push_back(model); q_tag.push_back(tag);
    endtask

    initial begin
        do_reset();
        step(1, 0, 16'h1234, "R3 seq");
        step(1, 0, 16'hFFFF, "R3 seq, offset ignored");
        step(1, 1, 16'h0010, "R4 forward branch");
        step(1, 1, 16'h0000, "R4 zero offset");
        step(1, 1, 16'hFFFE, "R5 minus one");
        step(1, 1, 16'hFFF0, "R5 backward");
        step(0, 1, 16'h7FFF, "R7 hold with taken");
        step(0, 0, 16'h0000, "R7 hold");
        step(1, 0, 16'h0000, "R8 resume");
        // R6 underflow: go far below zero.
        step(1, 1, 16'h8000, "R6 wrap below zero");
        step(1, 1, 16'h8000, "R6 wrap again");
        for (int i = 0; i < 8; i++) step(1, 1, 16'h7FFF, "R6 climb");
        step(1, 0, 16'h0000, "R3 after wrap");
        do_reset();
        step(1, 1, 16'h0003, "R4 after reset");
        // R6 overflow: climb from reset until the count passes the top.
        for (int i = 0; i < 32770; i++) step(1, 1, 16'h7FFF, "R6 overflow climb");
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule